// File: doc/BRIEF.md
# Synchronous DRAM Write Burst Engine with Truncation

This block models the memory side of a synchronous DRAM bank while it absorbs a burst write. A WRITE command carries the starting column and the first data word in the same clock. After that, one word per clock is committed to an internal word array at successive columns. A per-cycle mask input can suppress any single word without stalling the burst.

A burst ends when its configured length is used up. It also ends when a terminate command arrives or when a fresh WRITE starts a new burst. Fixed bursts of 1, 2, 4 or 8 words wrap inside their length-aligned column block. A full-page burst runs through the whole row, wraps from the last column to column 0, and continues until it is terminated. The word presented in the same clock as a terminate is discarded, so the last word kept is the one from the clock before.

A combinational read port returns any word of the array so that its contents can be observed.

Top module: `wburst_core`

## Requirements
- R1: After synchronous reset every word of the array reads as zero and `burst_active` is low.
- R2: A WRITE command (`cmd` = 2'b01) writes `wdata` to column `wcol` in the same clock, unless `wmask` is high.
- R3: With `cfg_fullpage` low, `cfg_blen` selects the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4 and 3 gives 8. After that many clocks, counted from the WRITE, the burst is over, `burst_active` is low and further data is not written.
- R4: In a fixed burst the column rises by one per clock and wraps inside the block of burst-length size that is aligned on that length and contains the starting column.
- R5: A word presented while `wmask` is high is not written, but the burst still advances by one column.
- R6: A terminate command (`cmd` = 2'b10) during a burst ends it. The word presented in the terminate clock is not written, the word from the preceding clock stays committed, and `burst_active` is low in the next clock.
- R7: While no burst runs, NOP (2'b00), the unused code 2'b11 and terminate write nothing and leave `burst_active` low.
- R8: With `cfg_fullpage` high, `cfg_blen` is ignored. The burst steps through the columns, wraps from the highest column to column 0, and runs until it is terminated or restarted.
- R9: A WRITE during a running burst ends the old burst at once and starts a new one at its own column, with the full new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_blen | input | 2 | Fixed burst length code (static) |
| cfg_fullpage | input | 1 | Full-page burst select (static) |
| cmd | input | 2 | Command: 00 NOP, 01 WRITE, 10 terminate, 11 treated as NOP |
| wcol | input | COL_W | Starting column, sampled with WRITE |
| wdata | input | DATA_W | Write data word for this clock |
| wmask | input | 1 | High suppresses this clock's word |
| burst_active | output | 1 | A burst is running |
| rd_col | input | COL_W | Read port column |
| rd_data | output | DATA_W | Word stored at `rd_col` |

## Verification
The assertions check on every cycle that a terminate or a mask never causes a write and that nothing is written when no burst runs. They also check that the first word of a WRITE lands at the commanded column, that a terminate clears the burst in the next cycle, and that the burst state follows the configured length after a WRITE. Whether the words land in the right columns across a whole burst, including the aligned and full-row wraps and a restart mid-burst, can only be seen from the bench's scenarios, which read the array back through the read port.

// File: rtl/wb_pkg.sv
package wb_pkg;

    typedef enum logic [1:0] {
        WB_NOP   = 2'b00,
        WB_WRITE = 2'b01,
        WB_TERM  = 2'b10,
        WB_RSVD  = 2'b11
    } wb_cmd_e;

    // Low-bit mask of a fixed burst block: length code k -> 2**k - 1
    function automatic logic [15:0] wb_blk_mask(input logic [1:0] code);
        return (16'd1 << code) - 16'd1;
    endfunction

    // Number of words still to come after the first word of a fixed burst
    function automatic logic [2:0] wb_rest_len(input logic [1:0] code);
        logic [3:0] n;
        n = (4'd1 << code) - 4'd1;
        return n[2:0];
    endfunction

endpackage

// File: rtl/wb_col_step.sv
module wb_col_step #(
    parameter int COL_W = 6
) (
    input  logic [COL_W-1:0] col,
    input  logic [1:0]       blen,
    input  logic             fullpage,
    output logic [COL_W-1:0] col_next
);
    import wb_pkg::*;

    logic [15:0]      wide_mask;
    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] col_inc;

    always_comb begin
        wide_mask = wb_blk_mask(blen);
        wrap_mask = fullpage ? '1 : wide_mask[COL_W-1:0];
        col_inc   = col + 1'b1;
        col_next  = (col & ~wrap_mask) | (col_inc & wrap_mask);
    end

endmodule

// File: rtl/wb_burst_ctrl.sv
module wb_burst_ctrl #(
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cmd,
    input  logic [COL_W-1:0] wcol,
    input  logic             wmask,
    input  logic [1:0]       cfg_blen,
    input  logic             cfg_fullpage,
    output logic             wr_en,
    output logic [COL_W-1:0] wr_col,
    output logic             burst_active
);
    import wb_pkg::*;

    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] col;
        logic [2:0]       left;
    } burst_st_t;

    burst_st_t        st_q, st_d;
    wb_cmd_e          op;
    logic             beat_now;
    logic [COL_W-1:0] col_after;

    always_comb begin
        op       = wb_cmd_e'(cmd);
        beat_now = (op == WB_WRITE) ||
                   (st_q.active && (op == WB_NOP || op == WB_RSVD));
        wr_col   = (op == WB_WRITE) ? wcol : st_q.col;
        wr_en    = beat_now && !wmask;
    end

    wb_col_step #(.COL_W(COL_W)) u_step (
        .col      (wr_col),
        .blen     (cfg_blen),
        .fullpage (cfg_fullpage),
        .col_next (col_after)
    );

    always_comb begin
        st_d = st_q;
        if (op == WB_WRITE) begin
            st_d.active = cfg_fullpage || (cfg_blen != 2'd0);
            st_d.col    = col_after;
            st_d.left   = wb_rest_len(cfg_blen);
        end else if (op == WB_TERM) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            st_d.col = col_after;
            if (!cfg_fullpage) begin
                if (st_q.left <= 3'd1) st_d.active = 1'b0;
                st_d.left = st_q.left - 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign burst_active = st_q.active;

endmodule

// File: rtl/wb_word_store.sv
module wb_word_store #(
    parameter int COL_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [COL_W-1:0]  wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [COL_W-1:0]  ra,
    output logic [DATA_W-1:0] rd
);
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];

endmodule

// File: rtl/wburst_core.sv
module wburst_core #(
    parameter int COL_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_blen,
    input  logic              cfg_fullpage,
    input  logic [1:0]        cmd,
    input  logic [COL_W-1:0]  wcol,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wmask,
    output logic              burst_active,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    logic             wr_en;
    logic [COL_W-1:0] wr_col;

    wb_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .wcol         (wcol),
        .wmask        (wmask),
        .cfg_blen     (cfg_blen),
        .cfg_fullpage (cfg_fullpage),
        .wr_en        (wr_en),
        .wr_col       (wr_col),
        .burst_active (burst_active)
    );

    wb_word_store #(.COL_W(COL_W), .DATA_W(DATA_W)) u_store (
        .clk (clk),
        .rst (rst),
        .we  (wr_en),
        .wa  (wr_col),
        .wd  (wdata),
        .ra  (rd_col),
        .rd  (rd_data)
    );

endmodule

// File: rtl/wb_chk.sv
module wb_chk #(
    parameter int COL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cmd,
    input logic [COL_W-1:0] wcol,
    input logic             wmask,
    input logic [1:0]       cfg_blen,
    input logic             cfg_fullpage,
    input logic             burst_active,
    input logic             wr_en,
    input logic [COL_W-1:0] wr_col
);
    // R6
    term_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b10) |-> !wr_en);

    // R6
    term_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b10) |=> !burst_active);

    // R5
    mask_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        wmask |-> !wr_en);

    // R2
    first_beat_col_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b01 && !wmask) |-> (wr_en && wr_col == wcol));

    // R3
    single_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b01 && cfg_blen == 2'd0 && !cfg_fullpage) |=> !burst_active);

    // R9
    restart_active_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b01 && (cfg_blen != 2'd0 || cfg_fullpage)) |=> burst_active);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!burst_active && cmd != 2'b01) |-> !wr_en);

endmodule

bind wburst_core wb_chk #(.COL_W(COL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd          (cmd),
    .wcol         (wcol),
    .wmask        (wmask),
    .cfg_blen     (cfg_blen),
    .cfg_fullpage (cfg_fullpage),
    .burst_active (burst_active),
    .wr_en        (wr_en),
    .wr_col       (wr_col)
);

// File: tb/sim_wburst_core.sv
`timescale 1ns/1ps
module sim_wburst_core;
    localparam int COL_W  = 6;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cfg_blen = 2'd0;
    logic              cfg_fullpage = 1'b0;
    logic [1:0]        cmd = 2'b00;
    logic [COL_W-1:0]  wcol = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              wmask = 1'b1;
    logic              burst_active;
    logic [COL_W-1:0]  rd_col = '0;
    logic [DATA_W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wburst_core #(.COL_W(COL_W), .DATA_W(DATA_W)) u0 (
        .clk, .rst, .cfg_blen, .cfg_fullpage, .cmd, .wcol, .wdata,
        .wmask, .burst_active, .rd_col, .rd_data
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: inputs set just after an edge, held across the next edge
    task automatic beat(input logic [1:0] c, input int col, input int d, input logic m);
        cmd = c; wcol = COL_W'(col); wdata = DATA_W'(d); wmask = m;
        @(posedge clk); #1;
        cmd = 2'b00; wmask = 1'b1;
    endtask

    task automatic word_is(input int col, input int exp, input string req);
        rd_col = COL_W'(col);
        #0.5;
        chk(rd_data == DATA_W'(exp), req, rd_data, exp);
    endtask

    task automatic act_is(input bit exp, input string req);
        chk(burst_active == exp, req, burst_active, exp);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 64; i++) begin
            rd_col = COL_W'(i); #0.05;
            if (rd_data != '0) chk(1'b0, "R1 array", rd_data, 0);
        end
        chk(1'b1, "R1 array", 0, 0);
        act_is(1'b0, "R1 active");
    endtask

    task automatic t_bl4_wrap;
        cfg_fullpage = 0; cfg_blen = 2'd2;
        beat(2'b01, 5, 8'hA0, 0);
        beat(2'b00, 0, 8'hA1, 0);
        beat(2'b00, 0, 8'hA2, 0);
        beat(2'b00, 0, 8'hA3, 0);
        act_is(1'b0, "R3 bl4 end");
        word_is(5, 8'hA0, "R2 first beat");
        word_is(6, 8'hA1, "R4 bl4");
        word_is(7, 8'hA2, "R4 bl4");
        word_is(4, 8'hA3, "R4 bl4 wrap");
        word_is(8, 0, "R4 no spill");
    endtask

    task automatic t_bl8_mask;
        cfg_fullpage = 0; cfg_blen = 2'd3;
        beat(2'b01, 18, 8'hB0, 0);
        for (int i = 1; i < 8; i++) beat(2'b00, 0, 8'hB0 + i, (i == 2));
        act_is(1'b0, "R3 bl8 end");
        word_is(18, 8'hB0, "R2 bl8 first");
        word_is(19, 8'hB1, "R4 bl8");
        word_is(20, 0, "R5 masked");
        word_is(21, 8'hB3, "R5 advance");
        word_is(23, 8'hB5, "R4 bl8");
        word_is(16, 8'hB6, "R4 bl8 wrap");
        word_is(17, 8'hB7, "R4 bl8 wrap");
        word_is(24, 0, "R4 bl8 no spill");
    endtask

    task automatic t_bl2_end;
        cfg_fullpage = 0; cfg_blen = 2'd1;
        beat(2'b01, 33, 8'h31, 0);
        act_is(1'b1, "R3 bl2 running");
        beat(2'b00, 0, 8'h32, 0);
        act_is(1'b0, "R3 bl2 end");
        beat(2'b00, 0, 8'h55, 0);
        word_is(33, 8'h31, "R3 bl2");
        word_is(32, 8'h32, "R4 bl2 wrap");
        word_is(34, 0, "R3 after end");
    endtask

    task automatic t_bl1;
        cfg_fullpage = 0; cfg_blen = 2'd0;
        beat(2'b01, 40, 8'h40, 0);
        act_is(1'b0, "R3 bl1 end");
        beat(2'b00, 0, 8'h66, 0);
        word_is(40, 8'h40, "R3 bl1");
        word_is(41, 0, "R3 bl1 single");
    endtask

    task automatic t_term;
        cfg_fullpage = 0; cfg_blen = 2'd3;
        beat(2'b01, 48, 8'hD0, 0);
        beat(2'b00, 0, 8'hD1, 0);
        beat(2'b00, 0, 8'hD2, 0);
        beat(2'b10, 0, 8'hEE, 0);
        act_is(1'b0, "R6 term ends");
        beat(2'b00, 0, 8'h77, 0);
        word_is(50, 8'hD2, "R6 last kept");
        word_is(51, 0, "R6 term word dropped");
        word_is(52, 0, "R6 no later write");
    endtask

    task automatic t_idle_cmds;
        beat(2'b10, 9, 8'h99, 0);
        act_is(1'b0, "R7 idle term");
        beat(2'b11, 9, 8'h98, 0);
        beat(2'b00, 9, 8'h97, 0);
        act_is(1'b0, "R7 idle");
        word_is(9, 0, "R7 idle no write");
        word_is(52, 0, "R7 idle no write");
    endtask

    task automatic t_fullpage;
        cfg_fullpage = 1; cfg_blen = 2'd0;
        beat(2'b01, 60, 8'hC0, 0);
        for (int i = 1; i < 6; i++) beat(2'b00, 0, 8'hC0 + i, 0);
        act_is(1'b1, "R8 still running");
        beat(2'b10, 0, 8'hEE, 0);
        act_is(1'b0, "R8 terminated");
        word_is(60, 8'hC0, "R8 page");
        word_is(63, 8'hC3, "R8 page top");
        word_is(0, 8'hC4, "R8 page wrap");
        word_is(1, 8'hC5, "R8 page wrap");
        word_is(2, 0, "R8 term dropped");
        cfg_fullpage = 0;
    endtask

    task automatic t_restart;
        cfg_fullpage = 0; cfg_blen = 2'd2;
        beat(2'b01, 24, 8'h10, 0);
        beat(2'b00, 0, 8'h11, 0);
        beat(2'b01, 28, 8'h20, 0);
        beat(2'b00, 0, 8'h21, 0);
        beat(2'b00, 0, 8'h22, 0);
        act_is(1'b1, "R9 new burst length");
        beat(2'b00, 0, 8'h23, 0);
        act_is(1'b0, "R9 new burst end");
        word_is(25, 8'h11, "R9 old beat");
        word_is(26, 0, "R9 old burst cut");
        word_is(27, 0, "R9 old burst cut");
        word_is(28, 8'h20, "R9 new start");
        word_is(31, 8'h23, "R9 new last");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_bl4_wrap();
        t_bl8_mask();
        t_bl2_end();
        t_bl1();
        t_term();
        t_idle_cmds();
        t_fullpage();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule